// File: doc/BRIEF.md
# Register-Mapped Synchronous Serial Master

This block is a serial master that a processor drives through a small 16-bit register bus. Software chooses a frame length from 4 to 16 bits, the clock polarity and phase, and a two-stage clock divider. It then queues frames by writing the data register and collects the answers by reading that same register. Each direction has its own eight-frame queue. The shift engine sends every queued frame on `mosi` while toggling `sclk`. It holds `ssel_n` low for the length of each frame. For every frame sent, it captures one frame from `miso`, or from its own output when the internal loop is selected.

A status word reports the queue levels and whether the engine is busy. An interrupt status word gives the receive-level, transmit-level and receive-overrun conditions, each after its enable bit. These three conditions are ORed onto `irq`. An overrun is latched and stays set until software writes the interrupt register. Turning the port off halts the engine at once, parks the clock and empties both queues.

Top module: `sspm_core`

## Requirements
- R1: After reset, status reads 0x0003, all control registers read zero, `sclk` is low, `ssel_n` is high and `irq` is low.
- R2: The registers sit at byte offsets 0x00 (control 0, 16 bits), 0x04 (control 1, 7 bits), 0x08 (data), 0x0C (status, read only), 0x10 (prescale, 8 bits) and 0x14 (interrupt status on read, clear on write). Bits outside a register's width read as zero.
- R3: Control 0 bits [3:0] hold the frame length minus one. A value below 3 gives 4-bit frames.
- R4: Frames leave on `mosi` most significant bit first. Received frames read right-justified and zero-extended in the 16-bit data register.
- R5: Control 0 bit 6 sets the idle level of `sclk`. Control 0 bit 7 picks the capture edge: 0 captures on the first edge of each bit and 1 captures on the second. `sclk` returns to the idle level whenever no frame is running, and `ssel_n` is low only while a frame runs.
- R6: Each half period of `sclk` lasts max(1, prescale/2) × (control 0 bits [15:8] + 1) clock cycles.
- R7: Each transmitted frame produces exactly one received frame. With control 1 bit 3 set, the receiver takes the transmit bit internally and `miso` has no effect. With bit 3 clear, `miso` is sampled.
- R8: Each queue holds 8 frames. A data write to a full transmit queue is dropped. A data read from an empty receive queue returns 0.
- R9: Status bit 0 means the transmit queue is empty, bit 1 that it is not full, bit 2 that the receive queue is not empty, bit 3 that it is full, and bit 4 that the engine is busy or frames are waiting.
- R10: A frame that completes while the receive queue is full is discarded and sets the overrun flag. Any write to offset 0x14 clears the flag.
- R11: Interrupt status bit 0 is receive level ≥ 4 gated by control 1 bit 0. Bit 1 is transmit level ≤ 4 gated by control 1 bit 1. Bit 2 is the overrun flag gated by control 1 bit 2. `irq` is the OR of these three bits.
- R12: Clearing control 1 bit 4 stops the engine and returns `sclk` to the idle level. It raises `ssel_n`, empties both queues, and causes data writes to be dropped while the port stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | OR of the gated interrupt conditions |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ssel_n | output | 1 | Active-low frame select |
| miso | input | 1 | Serial data in |

## Verification
The stimulus table sends frames in all four polarity and phase settings at several lengths. A monitor captures `mosi` on the edge the chosen phase names, so an engine that shifts on the wrong edge, or sends the least significant bit first, produces a scrambled capture. Upper data bits beyond the frame length are loaded with ones, which exposes a design that fails to left-justify or mask. Directed cases cover four further areas:
- a nine-frame burst into a receive queue that is never read, which catches a ninth frame that overwrites or evicts stored data instead of being dropped and flagged;
- a slow divider setting, which checks the exact half-period length;
- a disable during an active frame, which catches a clock left mid-level or a queue that keeps stale frames;
- the 1-bit and 2-bit length codes, which must come out as 4-bit frames.

// File: rtl/sspm_pkg.sv
package sspm_pkg;
   localparam int unsigned WORD_W = 16;
   localparam int unsigned ADDR_W = 5;

   localparam logic [ADDR_W-1:0] OFS_CTL0 = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_CTL1 = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_DATA = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_PRE  = 5'h10;
   localparam logic [ADDR_W-1:0] OFS_INT  = 5'h14;

   // control 1 bit positions
   localparam int unsigned C1_RXIE = 0;
   localparam int unsigned C1_TXIE = 1;
   localparam int unsigned C1_OVIE = 2;
   localparam int unsigned C1_LOOP = 3;
   localparam int unsigned C1_EN   = 4;
   localparam int unsigned C1_W    = 7;

   // control 0 bit positions
   localparam int unsigned C0_CPOL = 6;
   localparam int unsigned C0_CPHA = 7;

   typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_t;
endpackage

// File: rtl/sspm_fifo.sv
module sspm_fifo #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sspm_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = store[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= din;
   end
endmodule

// File: rtl/sspm_baud.sv
module sspm_baud #(
   parameter int unsigned HALF_W = 7,
   parameter int unsigned RATE_W = 8,
   localparam int unsigned CNT_W = HALF_W + RATE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half_pre,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   logic [CNT_W-1:0] limit, cnt;
   logic [HALF_W-1:0] pre_eff;

   assign pre_eff = (half_pre == '0) ? HALF_W'(1) : half_pre;
   assign limit   = CNT_W'(pre_eff) * (CNT_W'(rate) + CNT_W'(1));
   assign tick    = run && (cnt == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/sspm_shift.sv
module sspm_shift
   import sspm_pkg::*;
#(
   parameter int unsigned FRAME_MAX = 16,
   parameter int unsigned FRAME_MIN = 4,
   localparam int unsigned DSS_W  = $clog2(FRAME_MAX),
   localparam int unsigned LEN_W  = $clog2(FRAME_MAX + 1),
   localparam int unsigned EDGE_W = LEN_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 cpol,
   input  logic                 cpha,
   input  logic [DSS_W-1:0]     dss,
   input  logic                 loopback,
   input  logic                 miso,
   input  logic                 tick,
   input  logic                 tx_avail,
   input  logic [FRAME_MAX-1:0] tx_word,
   output logic                 tx_pop,
   output logic                 running,
   output logic                 sclk,
   output logic                 mosi,
   output logic                 rx_push,
   output logic [FRAME_MAX-1:0] rx_word
);
   eng_state_t           state;
   logic [FRAME_MAX-1:0] tx_sh, rx_sh, rx_next;
   logic [EDGE_W-1:0]    edge_idx, last_edge;
   logic [LEN_W-1:0]     nbits;
   logic                 din, sample_edge;

   assign nbits       = (dss < DSS_W'(FRAME_MIN - 1)) ? LEN_W'(FRAME_MIN)
                                                      : LEN_W'(dss) + LEN_W'(1);
   assign last_edge   = {nbits, 1'b0} - EDGE_W'(1);
   assign sample_edge = (edge_idx[0] == cpha);
   assign din         = loopback ? tx_sh[FRAME_MAX-1] : miso;
   assign rx_next     = {rx_sh[FRAME_MAX-2:0], din};

   assign running = (state == ENG_RUN);
   assign mosi    = tx_sh[FRAME_MAX-1];
   assign tx_pop  = en && (state == ENG_IDLE) && tx_avail;
   assign rx_push = en && running && tick && (edge_idx == last_edge);
   assign rx_word = sample_edge ? rx_next : rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         sclk     <= 1'b0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         edge_idx <= '0;
      end else if (!en) begin
         state    <= ENG_IDLE;
         sclk     <= cpol;
         edge_idx <= '0;
      end else begin
         case (state)
            ENG_IDLE: begin
               sclk <= cpol;
               if (tx_avail) begin
                  tx_sh    <= tx_word << (LEN_W'(FRAME_MAX) - nbits);
                  rx_sh    <= '0;
                  edge_idx <= '0;
                  state    <= ENG_RUN;
               end
            end
            default: begin
               if (tick) begin
                  sclk <= ~sclk;
                  if (sample_edge)          rx_sh <= rx_next;
                  else if (edge_idx != '0)  tx_sh <= tx_sh << 1;
                  if (edge_idx == last_edge) state <= ENG_IDLE;
                  else                       edge_idx <= edge_idx + EDGE_W'(1);
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/sspm_core.sv
module sspm_core
   import sspm_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned FRAME_MIN  = 4,
   localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1),
   localparam int unsigned DSS_W  = $clog2(WORD_W),
   localparam int unsigned HALF_W = 7,
   localparam int unsigned RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   output logic              ssel_n,
   input  logic              miso
);
   generate
      if (FIFO_DEPTH < 4 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_fifo
         $error("sspm_core: FIFO_DEPTH must be a power of two of at least 4");
      end
      if (FRAME_MIN < 2 || FRAME_MIN > WORD_W) begin : g_bad_min
         $error("sspm_core: FRAME_MIN out of range");
      end
   endgenerate

   logic [WORD_W-1:0] cr0_q;
   logic [C1_W-1:0]   cr1_q;
   logic [7:0]        pre_q;
   logic              ovr_q;

   logic wr_cycle, rd_cycle, en;
   logic data_wr, data_rd, isr_clr;
   logic tx_full, tx_empty, rx_full, rx_empty;
   logic [CNT_W-1:0]  tx_cnt, rx_cnt;
   logic [WORD_W-1:0] tx_dout, rx_dout, rx_word;
   logic tx_pop, eng_run, rx_push, tick, ovr_set;
   logic [WORD_W-1:0] status_w, isr_w;

   assign wr_cycle = bus_sel && bus_wr;
   assign rd_cycle = bus_sel && !bus_wr;
   assign en       = cr1_q[C1_EN];
   assign data_wr  = wr_cycle && (bus_addr == OFS_DATA) && en;
   assign data_rd  = rd_cycle && (bus_addr == OFS_DATA);
   assign isr_clr  = wr_cycle && (bus_addr == OFS_INT);
   assign ovr_set  = rx_push && rx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr0_q <= '0;
         cr1_q <= '0;
         pre_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         if (wr_cycle && bus_addr == OFS_CTL0) cr0_q <= bus_wdata;
         if (wr_cycle && bus_addr == OFS_CTL1) cr1_q <= bus_wdata[C1_W-1:0];
         if (wr_cycle && bus_addr == OFS_PRE)  pre_q <= bus_wdata[7:0];
         if (ovr_set)      ovr_q <= 1'b1;
         else if (isr_clr) ovr_q <= 1'b0;
      end
   end

   sspm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(!en),
      .push(data_wr), .din(bus_wdata), .pop(tx_pop),
      .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   sspm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(!en),
      .push(rx_push), .din(rx_word), .pop(data_rd),
      .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   sspm_baud #(.HALF_W(HALF_W), .RATE_W(RATE_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(eng_run),
      .half_pre(pre_q[7:1]), .rate(cr0_q[15:8]), .tick(tick)
   );

   sspm_shift #(.FRAME_MAX(WORD_W), .FRAME_MIN(FRAME_MIN)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cpol(cr0_q[C0_CPOL]), .cpha(cr0_q[C0_CPHA]), .dss(cr0_q[DSS_W-1:0]),
      .loopback(cr1_q[C1_LOOP]), .miso(miso), .tick(tick),
      .tx_avail(!tx_empty), .tx_word(tx_dout), .tx_pop(tx_pop),
      .running(eng_run), .sclk(sclk), .mosi(mosi),
      .rx_push(rx_push), .rx_word(rx_word)
   );

   assign ssel_n   = !eng_run;
   assign status_w = {11'b0, (eng_run || !tx_empty), rx_full, !rx_empty, !tx_full, tx_empty};
   assign isr_w    = {13'b0,
                      cr1_q[C1_OVIE] && ovr_q,
                      cr1_q[C1_TXIE] && (tx_cnt <= CNT_W'(FIFO_DEPTH / 2)),
                      cr1_q[C1_RXIE] && (rx_cnt >= CNT_W'(FIFO_DEPTH / 2))};
   assign irq      = |isr_w;

   always_comb begin
      case (bus_addr)
         OFS_CTL0: bus_rdata = cr0_q;
         OFS_CTL1: bus_rdata = {{(WORD_W - C1_W){1'b0}}, cr1_q};
         OFS_DATA: bus_rdata = rx_empty ? '0 : rx_dout;
         OFS_STAT: bus_rdata = status_w;
         OFS_PRE:  bus_rdata = {8'b0, pre_q};
         OFS_INT:  bus_rdata = isr_w;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sspm_chk.sv
module sspm_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic cpol,
   input logic sclk,
   input logic ssel_n,
   input logic rx_push,
   input logic rx_full,
   input logic ovr_q,
   input logic ovr_set,
   input logic isr_clr,
   input logic tx_empty
);
   // R5
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ssel_n && $stable(cpol)) |-> (sclk == cpol));

   // R10
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(rx_full));

   // R10
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_clr && !ovr_set) |=> !ovr_q);

   // R7
   frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> ssel_n);

   // R12
   stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |=> (ssel_n && tx_empty));
endmodule

bind sspm_core sspm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .cpol(cr0_q[6]), .sclk(sclk),
   .ssel_n(ssel_n), .rx_push(rx_push), .rx_full(rx_full), .ovr_q(ovr_q),
   .ovr_set(ovr_set), .isr_clr(isr_clr), .tx_empty(tx_empty)
);

// File: tb/tb_sspm_core.sv
module tb_sspm_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq, sclk, mosi, ssel_n;
   logic        miso = 1'b1;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] cap = '0;
   logic        samp_lvl = 1'b1;

   always #4 clk = ~clk;

   sspm_core dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sclk(sclk), .mosi(mosi), .ssel_n(ssel_n), .miso(miso)
   );

   // mosi captured on the edge the selected phase samples on
   always @(sclk) if (sclk === samp_lvl) cap <= {cap[14:0], mosi};

   // fields: [25] cpha, [24] cpol, [19:16] length-1, [15:0] data
   localparam logic [31:0] VEC [6] = '{
      32'h0007_00A5, 32'h010F_BEEF, 32'h0203_FFF9,
      32'h030B_0ABC, 32'h0009_F155, 32'h020F_8001
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] st;
      for (int i = 0; i < 2000; i++) begin
         rd(5'h0C, st);
         if ((st & 16'h0011) == 16'h0001) return;
      end
      check("R9 engine never went idle", st, 16'h0001);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      logic [15:0] v, m;
      time t0, t1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'h0C, v); check("R1 status after reset", v, 16'h0003);
      rd(5'h00, v); check("R1 control0 after reset", v, 16'h0000);
      rd(5'h04, v); check("R1 control1 after reset", v, 16'h0000);
      check("R1 sclk/ssel_n/irq after reset", {13'b0, sclk, ssel_n, irq}, 16'h0002);

      // R2 register widths and readback
      wr(5'h00, 16'h1234); rd(5'h00, v); check("R2 control0 readback", v, 16'h1234);
      wr(5'h04, 16'hFFFF); rd(5'h04, v); check("R2 control1 width", v, 16'h007F);
      wr(5'h10, 16'h01FE); rd(5'h10, v); check("R2 prescale width", v, 16'h00FE);
      wr(5'h04, 16'h0000); wr(5'h10, 16'h0000);

      // table: loopback frames in every mode and several lengths (R4 R5 R7)
      for (int i = 0; i < 6; i++) begin
         logic [3:0] dss;
         logic       cpol, cpha;
         dss  = VEC[i][19:16];
         cpol = VEC[i][24];
         cpha = VEC[i][25];
         m = 16'((32'd1 << (dss + 1)) - 1);
         samp_lvl = ~(cpol ^ cpha);
         wr(5'h04, 16'h0000);
         wr(5'h00, {8'h00, cpha, cpol, 2'b00, dss});
         wr(5'h04, 16'h0018);
         wr(5'h08, VEC[i][15:0]);
         wait_idle();
         rd(5'h08, v);
         check("R4 R7 loopback word right-justified", v, VEC[i][15:0] & m);
         check("R4 R5 mosi MSB-first on capture edge", cap & m, VEC[i][15:0] & m);
         check("R5 sclk parked at polarity", {15'b0, sclk}, {15'b0, cpol});
         check("R5 select released after frame", {15'b0, ssel_n}, 16'h0001);
      end

      // R3 length codes below 3 give 4-bit frames
      wr(5'h04, 16'h0000); wr(5'h00, 16'h0001); wr(5'h04, 16'h0018);
      wr(5'h08, 16'hFFFF); wait_idle(); rd(5'h08, v);
      check("R3 short code clamps to 4 bits", v, 16'h000F);

      // R7 miso sampled without loopback
      wr(5'h04, 16'h0000); wr(5'h00, 16'h0007); wr(5'h04, 16'h0010);
      miso = 1'b1; wr(5'h08, 16'h0000); wait_idle(); rd(5'h08, v);
      check("R7 miso ones captured", v, 16'h00FF);
      miso = 1'b0; wr(5'h08, 16'h00FF); wait_idle(); rd(5'h08, v);
      check("R7 miso zeros captured", v, 16'h0000);
      miso = 1'b1;

      // R6 half period = (4/2)*(2+1) = 6 cycles
      wr(5'h04, 16'h0000); wr(5'h10, 16'h0004); wr(5'h00, 16'h0203);
      wr(5'h04, 16'h0018); wr(5'h08, 16'h0005);
      @(sclk); t0 = $time;
      @(sclk); t1 = $time;
      check("R6 half period cycles", 16'((t1 - t0) / 8), 16'd6);
      wait_idle();
      wr(5'h04, 16'h0000); wr(5'h10, 16'h0000);

      // R8 R9 R10 R11 overrun with a receive queue never read
      wr(5'h00, 16'h0007); wr(5'h04, 16'h001D);
      for (int k = 1; k <= 9; k++) wr(5'h08, 16'(k));
      wait_idle();
      rd(5'h0C, v); check("R9 status with full receive queue", v, 16'h000F);
      rd(5'h14, v); check("R10 R11 level and overrun interrupts", v, 16'h0005);
      check("R11 irq raised", {15'b0, irq}, 16'h0001);
      wr(5'h14, 16'h0000);
      rd(5'h14, v); check("R10 overrun cleared by write", v, 16'h0001);
      for (int k = 1; k <= 8; k++) begin
         rd(5'h08, v); check("R8 R10 stored frames kept in order", v, 16'(k));
      end
      rd(5'h08, v); check("R8 empty receive read returns 0", v, 16'h0000);
      rd(5'h14, v); check("R11 receive interrupt drops", v, 16'h0000);
      check("R11 irq low", {15'b0, irq}, 16'h0000);

      // R8 R11 transmit queue full with a very slow clock, polarity high
      wr(5'h04, 16'h0000); wr(5'h10, 16'h00FE); wr(5'h00, 16'hFF4F);
      wr(5'h04, 16'h0012);
      rd(5'h14, v); check("R11 transmit interrupt when empty", v, 16'h0002);
      for (int k = 0; k < 10; k++) wr(5'h08, 16'h1000 + 16'(k));
      rd(5'h0C, v); check("R8 R9 transmit queue full and busy", v, 16'h0010);
      rd(5'h14, v); check("R11 transmit interrupt off when full", v, 16'h0000);
      check("R5 select low during frame", {15'b0, ssel_n}, 16'h0000);

      // R12 disable mid-frame
      wr(5'h04, 16'h0000);
      repeat (2) @(negedge clk);
      rd(5'h0C, v); check("R12 queues flushed, not busy", v, 16'h0003);
      check("R12 sclk at polarity, select high", {14'b0, sclk, ssel_n}, 16'h0003);
      wr(5'h08, 16'hAAAA);
      rd(5'h0C, v); check("R12 write dropped while off", v, 16'h0003);

      report();
   end
endmodule